// File: doc/BRIEF.md
# Timer and Watchdog with Shared Divider

This block pairs a small up-counting timer with a watchdog. One programmable power-of-two divider sits between them and is steered by a single assignment bit. When the bit selects the timer, the divider is a prescaler on the timer's count source. When it selects the watchdog, the divider stretches the watchdog's base period into a longer timeout.

The timer counts either every cycle of the block clock, which stands for the instruction clock, or edges on an external pin. The pin is synchronised first, and an edge-select bit picks the rising or the falling edge. When the timer wraps from its all-ones value to zero, it sets a sticky overflow flag.

The watchdog counts pulses from an external slow tick, which stands for a separate oscillator. After a set number of ticks it reaches the end of its base period. A clear command restarts it. A timeout raises a one-cycle reset request while the device is awake, and a one-cycle wake request while it is sleeping.

Top module: `shared_div_wdog`

## Requirements
- R1: After reset, tmr_count is 0, tmr_ovf is 0, and both rst_req and wake_req are 0.
- R2: With src_sel=0 (internal clock) and div_to_wdt=1, tmr_count rises by exactly one on every clock edge.
- R3: With div_to_wdt=0, the timer advances once per 2^(rate+1) source events. For example, 40 cycles give 10 counts at rate=1 and 20 cycles give 10 counts at rate=0.
- R4: With src_sel=1, the timer counts pin transitions, and only those of the selected direction. edge_sel=0 selects low-to-high and edge_sel=1 selects high-to-low. A pin held steady, or a transition in the other direction, leaves tmr_count unchanged.
- R5: A wrap of tmr_count from 0xFF to 0x00 sets tmr_ovf. The flag stays set until ovf_clr is high on a clock edge with no wrap. When a wrap and ovf_clr coincide, the flag is set.
- R6: With div_to_wdt=0, a timeout occurs on the WDT_TICKS-th wdt_tick after a clear (default 18).
- R7: With div_to_wdt=1, a timeout occurs on the (WDT_TICKS * 2^rate)-th wdt_tick after a clear. For example, rate=2 gives tick 72.
- R8: A wdt_clear restarts the base count. With div_to_wdt=1 it also empties the divider. A tick in the same cycle as a clear is not counted and causes no timeout, and no request follows a clear cycle.
- R9: While wdt_en=0, no ticks are counted and no request is raised. The base count is held at zero, so after re-enabling, a full period is needed.
- R10: A timeout produces a one-cycle pulse in the cycle after the terminal tick. The pulse is on rst_req when sleeping=0 and on wake_req when sleeping=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the internal count source |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 1 | Timer source: 0 internal clock, 1 external pin |
| edge_sel | input | 1 | Pin edge: 0 rising, 1 falling |
| div_to_wdt | input | 1 | Divider owner: 1 watchdog, 0 timer |
| rate | input | RATE_W | Divider rate exponent |
| ext_pin | input | 1 | Asynchronous external count pin |
| wdt_en | input | 1 | Watchdog enable |
| wdt_tick | input | 1 | One-cycle pulse per watchdog base tick |
| wdt_clear | input | 1 | Watchdog clear command |
| sleeping | input | 1 | Device is in its low-power state |
| ovf_clr | input | 1 | Clears the timer overflow flag |
| tmr_count | output | TMR_W | Timer value |
| tmr_ovf | output | 1 | Sticky timer overflow flag |
| rst_req | output | 1 | Watchdog reset request pulse |
| wake_req | output | 1 | Watchdog wake-up request pulse |

## Verification
On every cycle, the properties check the following:
- the timer never moves by anything other than one step;
- a wrap always leaves the overflow flag set, and the flag never drops without a clear;
- a request always matches the sleep state of the previous cycle;
- no request appears while the watchdog was disabled or just after a clear.

Some behaviours only the bench scenarios can show: the exact timeout tick for each divider assignment and rate, the prescaled timer rate, the edge-direction filtering, and the divider being emptied by a clear.

// File: rtl/wdp_pkg.sv
package wdp_pkg;
   typedef enum logic {SRC_INTERNAL = 1'b0, SRC_PIN = 1'b1} tmr_src_e;

   function automatic int unsigned div_mask(input int unsigned log2r);
      return (32'd1 << log2r) - 32'd1;
   endfunction
endpackage

// File: rtl/wdp_edge_detect.sv
module wdp_edge_detect #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic fall_sel,
   output logic evt
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   cur;

   generate
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= pin;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) sync_q[i] <= 1'b0;
               else        sync_q[i] <= sync_q[i-1];
            end
         end
      end
   endgenerate

   assign cur = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= cur;
   end

   always_comb begin
      if (fall_sel) evt = prev_q & ~cur;
      else          evt = cur & ~prev_q;
   end
endmodule

// File: rtl/wdp_divider.sv
module wdp_divider #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt,
   input  logic             clr,
   input  logic [DIV_W-1:0] mask,
   output logic             out
);
   logic [DIV_W-1:0] cnt_q;
   logic             term;

   assign term = (cnt_q >= mask);
   assign out  = evt & term & ~clr;

   always_ff @(posedge clk) begin
      if (!rst_n || clr)  cnt_q <= '0;
      else if (evt) begin
         if (term) cnt_q <= '0;
         else      cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/wdp_timer.sv
module wdp_timer #(
   parameter int TMR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             ovf_clr,
   output logic [TMR_W-1:0] count,
   output logic             ovf
);
   logic wrap;

   assign wrap = inc & (count == {TMR_W{1'b1}});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         ovf   <= 1'b0;
      end else begin
         if (inc)          count <= count + 1'b1;
         if (wrap)         ovf   <= 1'b1;
         else if (ovf_clr) ovf   <= 1'b0;
      end
   end
endmodule

// File: rtl/wdp_watchdog.sv
module wdp_watchdog #(
   parameter int WDT_TICKS = 18
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic tick,
   input  logic clr,
   input  logic timeout,
   input  logic sleeping,
   output logic base_exp,
   output logic rst_req,
   output logic wake_req
);
   localparam int BASE_W = (WDT_TICKS > 1) ? $clog2(WDT_TICKS) : 1;
   localparam logic [BASE_W-1:0] LAST = BASE_W'(WDT_TICKS - 1);

   logic [BASE_W-1:0] base_q;

   assign base_exp = en & tick & ~clr & (base_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || clr || !en) base_q <= '0;
      else if (tick) begin
         if (base_exp) base_q <= '0;
         else          base_q <= base_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rst_req  <= 1'b0;
         wake_req <= 1'b0;
      end else begin
         rst_req  <= timeout & ~sleeping;
         wake_req <= timeout & sleeping;
      end
   end
endmodule

// File: rtl/shared_div_wdog.sv
module shared_div_wdog #(
   parameter int TMR_W       = 8,
   parameter int RATE_W      = 3,
   parameter int WDT_TICKS   = 18,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_sel,
   input  logic              edge_sel,
   input  logic              div_to_wdt,
   input  logic [RATE_W-1:0] rate,
   input  logic              ext_pin,
   input  logic              wdt_en,
   input  logic              wdt_tick,
   input  logic              wdt_clear,
   input  logic              sleeping,
   input  logic              ovf_clr,
   output logic [TMR_W-1:0]  tmr_count,
   output logic              tmr_ovf,
   output logic              rst_req,
   output logic              wake_req
);
   import wdp_pkg::*;

   localparam int DIV_W = 2 ** RATE_W;

   if (TMR_W < 2) begin : g_bad_tmr
      $error("TMR_W must be at least 2");
   end
   if (RATE_W < 1 || RATE_W > 4) begin : g_bad_rate
      $error("RATE_W must be between 1 and 4");
   end
   if (WDT_TICKS < 1) begin : g_bad_ticks
      $error("WDT_TICKS must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   tmr_src_e         src;
   logic             pin_evt;
   logic             src_evt;
   logic             base_exp;
   logic             div_evt;
   logic             div_clr;
   logic             div_out;
   logic             tmr_inc;
   logic             timeout;
   logic [DIV_W-1:0] mask;
   int unsigned      log2r;

   assign src = tmr_src_e'(src_sel);

   wdp_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (ext_pin),
      .fall_sel (edge_sel),
      .evt      (pin_evt)
   );

   always_comb begin
      src_evt = (src == SRC_PIN) ? pin_evt : 1'b1;
      log2r   = div_to_wdt ? int'(rate) : int'(rate) + 1;
      mask    = DIV_W'(div_mask(log2r));
      div_evt = div_to_wdt ? base_exp : src_evt;
      div_clr = div_to_wdt & wdt_clear;
      tmr_inc = div_to_wdt ? src_evt : div_out;
      timeout = div_to_wdt ? div_out : base_exp;
   end

   wdp_divider #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (div_evt),
      .clr   (div_clr),
      .mask  (mask),
      .out   (div_out)
   );

   wdp_timer #(.TMR_W(TMR_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (tmr_inc),
      .ovf_clr (ovf_clr),
      .count   (tmr_count),
      .ovf     (tmr_ovf)
   );

   wdp_watchdog #(.WDT_TICKS(WDT_TICKS)) u_wdt (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (wdt_en),
      .tick     (wdt_tick),
      .clr      (wdt_clear),
      .timeout  (timeout),
      .sleeping (sleeping),
      .base_exp (base_exp),
      .rst_req  (rst_req),
      .wake_req (wake_req)
   );
endmodule

// File: rtl/shared_div_wdog_chk.sv
module shared_div_wdog_chk #(
   parameter int TMR_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wdt_en,
   input logic             wdt_clear,
   input logic             sleeping,
   input logic             ovf_clr,
   input logic [TMR_W-1:0] tmr_count,
   input logic             tmr_ovf,
   input logic             rst_req,
   input logic             wake_req
);
   AST_WAKE_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> $past(sleeping)); // R10
   AST_RESET_ONLY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> !$past(sleeping)); // R10
   AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req || wake_req) |-> $past(wdt_en)); // R9
   AST_CLEAR_SUPPRESSES: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_clear |=> !(rst_req || wake_req)); // R8
   AST_TMR_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_count != $past(tmr_count)) |-> (tmr_count == TMR_W'($past(tmr_count) + 1'b1))); // R2
   AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(tmr_count) == {TMR_W{1'b1}}) && (tmr_count == '0)) |-> tmr_ovf); // R5
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_ovf && !ovf_clr) |=> tmr_ovf); // R5
endmodule

bind shared_div_wdog shared_div_wdog_chk #(.TMR_W(TMR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wdt_en    (wdt_en),
   .wdt_clear (wdt_clear),
   .sleeping  (sleeping),
   .ovf_clr   (ovf_clr),
   .tmr_count (tmr_count),
   .tmr_ovf   (tmr_ovf),
   .rst_req   (rst_req),
   .wake_req  (wake_req)
);

// File: tb/shared_div_wdog_bench.sv
`timescale 1ns/1ps
module shared_div_wdog_bench;
   localparam int TMR_W  = 8;
   localparam int RATE_W = 3;
   localparam int TICKS  = 18;

   typedef struct {
      int kind;   // 0 = reset request, 1 = wake request
      int tick;
   } evt_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              src_sel = 1'b0, edge_sel = 1'b0, div_to_wdt = 1'b1;
   logic [RATE_W-1:0] rate = '0;
   logic              ext_pin = 1'b0, wdt_en = 1'b0, wdt_tick = 1'b0;
   logic              wdt_clear = 1'b0, sleeping = 1'b0, ovf_clr = 1'b0;
   logic [TMR_W-1:0]  tmr_count;
   logic              tmr_ovf, rst_req, wake_req;

   int   n_checks = 0, n_fail = 0, sent = 0, events_seen = 0;
   bit   finished = 1'b0;
   evt_t exp_q[$];

   always #2.5 clk = ~clk;

   shared_div_wdog #(.TMR_W(TMR_W), .RATE_W(RATE_W), .WDT_TICKS(TICKS)) u_shared_div_wdog (
      .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .edge_sel(edge_sel),
      .div_to_wdt(div_to_wdt), .rate(rate), .ext_pin(ext_pin), .wdt_en(wdt_en),
      .wdt_tick(wdt_tick), .wdt_clear(wdt_clear), .sleeping(sleeping),
      .ovf_clr(ovf_clr), .tmr_count(tmr_count), .tmr_ovf(tmr_ovf),
      .rst_req(rst_req), .wake_req(wake_req));

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic expect_evt(input int kind, input int tick);
      evt_t e;
      e.kind = kind;
      e.tick = tick;
      exp_q.push_back(e);
   endtask

   task automatic send_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); wdt_tick = 1'b1; sent++;
         @(negedge clk); wdt_tick = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic wdt_clr(input bit with_tick);
      @(negedge clk); wdt_clear = 1'b1; wdt_tick = with_tick;
      @(negedge clk); wdt_clear = 1'b0; wdt_tick = 1'b0; sent = 0;
      @(negedge clk);
   endtask

   // monitor: pops the scoreboard on every request pulse
   always @(negedge clk) begin
      if (rst_n && (rst_req || wake_req)) begin
         events_seen++;
         if (exp_q.size() == 0) begin
            n_checks++; n_fail++;
            $display("FAIL R10 unexpected request actual=kind%0d@%0d expected=none",
                     wake_req ? 1 : 0, sent);
         end else begin
            evt_t e;
            e = exp_q.pop_front();
            check("R10 request kind", wake_req ? 1 : 0, e.kind);
            check("R6/R7 timeout tick", sent, e.tick);
         end
      end
   end

   initial begin
      #(200000 * 5.0);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int c0;
      int seen0;
      cyc(3);
      check("R1 count", int'(tmr_count), 0);
      check("R1 ovf", int'(tmr_ovf), 0);
      check("R1 requests", int'(rst_req | wake_req), 0);
      rst_n = 1'b1;

      // R2 internal clock, no prescale
      cyc(2); c0 = int'(tmr_count);
      cyc(10);
      check("R2 ten cycles", int'(tmr_count), (c0 + 10) % 256);

      // R3 prescaler on the timer
      div_to_wdt = 1'b0; rate = 3'd1;
      cyc(1); c0 = int'(tmr_count);
      cyc(40);
      check("R3 rate1 40 cycles", (int'(tmr_count) - c0 + 256) % 256, 10);
      rate = 3'd0;
      cyc(1); c0 = int'(tmr_count);
      cyc(20);
      check("R3 rate0 20 cycles", (int'(tmr_count) - c0 + 256) % 256, 10);

      // R5 overflow flag
      div_to_wdt = 1'b1;
      while (tmr_count != 8'h80) @(negedge clk);
      ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
      check("R5 cleared", int'(tmr_ovf), 0);
      while (tmr_count != 8'hFE) @(negedge clk);
      check("R5 before wrap", int'(tmr_ovf), 0);
      cyc(2);
      check("R5 wrapped count", int'(tmr_count), 0);
      check("R5 set on wrap", int'(tmr_ovf), 1);
      cyc(5);
      check("R5 sticky", int'(tmr_ovf), 1);
      ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
      check("R5 clear", int'(tmr_ovf), 0);
      while (tmr_count != 8'hFF) @(negedge clk);
      ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
      check("R5 set wins over clear", int'(tmr_ovf), 1);

      // R4 external pin edges
      src_sel = 1'b1; edge_sel = 1'b0; ext_pin = 1'b0;
      cyc(6); c0 = int'(tmr_count);
      ext_pin = 1'b1; cyc(5);
      check("R4 rising counted", int'(tmr_count), (c0 + 1) % 256);
      ext_pin = 1'b0; cyc(5);
      check("R4 falling ignored", int'(tmr_count), (c0 + 1) % 256);
      cyc(10);
      check("R4 steady pin ignored", int'(tmr_count), (c0 + 1) % 256);
      edge_sel = 1'b1; cyc(3); c0 = int'(tmr_count);
      ext_pin = 1'b1; cyc(5);
      check("R4 rising ignored", int'(tmr_count), c0);
      ext_pin = 1'b0; cyc(5);
      check("R4 falling counted", int'(tmr_count), (c0 + 1) % 256);
      src_sel = 1'b0;

      // R6 base period, R10 reset while awake
      div_to_wdt = 1'b0; wdt_en = 1'b1; sleeping = 1'b0;
      wdt_clr(1'b0);
      expect_evt(0, TICKS); expect_evt(0, 2 * TICKS);
      send_ticks(2 * TICKS);

      // R10 wake while sleeping
      sleeping = 1'b1; wdt_clr(1'b0);
      expect_evt(1, TICKS);
      send_ticks(TICKS);
      sleeping = 1'b0;

      // R7 postscaler rate 2
      div_to_wdt = 1'b1; rate = 3'd2; wdt_clr(1'b0);
      expect_evt(0, 4 * TICKS);
      send_ticks(4 * TICKS);

      // R8 clear empties base count and divider
      rate = 3'd1; wdt_clr(1'b0);
      send_ticks(TICKS + 12);
      wdt_clr(1'b0);
      send_ticks(TICKS - 1);
      wdt_clr(1'b1);
      seen0 = events_seen;
      cyc(3);
      check("R8 no request after clear with tick", events_seen, seen0);
      expect_evt(0, 2 * TICKS);
      send_ticks(2 * TICKS);

      // R9 disabled watchdog
      div_to_wdt = 1'b0; wdt_clr(1'b0);
      send_ticks(10);
      wdt_en = 1'b0; seen0 = events_seen;
      send_ticks(3 * TICKS);
      check("R9 silent while disabled", events_seen, seen0);
      wdt_en = 1'b1; sent = 0;
      expect_evt(0, TICKS);
      send_ticks(TICKS);

      cyc(5);
      check("R6 scoreboard drained", exp_q.size(), 0);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule